// File: doc/BRIEF.md
# Buffered Flash Program Sequencer (host side)

This block is the host-side controller for a flash device's buffered factory-programming mode. A start pulse supplies a block base address and a word offset inside that block. The block then drives the flash command interface as a bus master. It sends two setup writes and then streams data words taken from a valid/ready input.

Every data word goes to the same start address, because the flash steps its own internal pointer. Before each write the block reads the status word and waits until the flash reports that it is ready. A short final buffer is filled out with all-ones words. When the stream ends, or the block is full, the block writes once to the first word of the following block to leave the mode. It then reads status until the flash reports that it has exited, and reports a program error or a success.

Status is only ever fetched with plain bus reads. No read-status command is issued while the mode is active, because the flash would take that command as data. Each poll loop has a bound, and a flash that never becomes ready ends the run with a timeout.

Top module: `bufprog_seq`

## Requirements
- R1: After an accepted start, the first two bus writes go to the start address and carry 0x0080 and then 0x00D0. The start address is the block base with its low log2(BLK_WORDS) bits replaced by the offset.
- R2: A start whose offset is not a multiple of BUF_WORDS (32) produces no bus access. It raises err_align together with a done pulse in the next cycle.
- R3: Every setup and data write lands on the start address, never on an incremented address.
- R4: Before each data, pad or exit write, a status read has returned bit 0 = 0 (ready) since the previous write.
- R5: When the stream ends part-way through a 32-word buffer, the rest of that buffer is written with 0xFFFF.
- R6: Streams longer than one buffer continue into further buffers with no repeat of the two setup writes.
- R7: The run ends with one write of 0xFFFF to word 0 of the next block (block number plus one, wrapping). The block then keeps reading status until bit 7 reads 1, and only after that pulses done.
- R8: err_prog takes the value of status bit 4 in the read that showed bit 7 = 1.
- R9: When a buffer ends on the last word of the block, the block exits even if more words are offered. No further input word is accepted.
- R10: After TMO_POLLS (16) consecutive status reads without the awaited bit, the run ends with err_tmo and done, and no further write is made.
- R11: in_ready is high only while busy and waiting for a stream word. done lasts exactly one cycle.
- R12: Stream words are written unchanged whatever their value, including 0x0070, 0x0080 and 0x00D0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled while idle |
| blk_base | input | AW | Any word address inside the target block |
| start_off | input | log2(BLK_WORDS) | Word offset of the first buffer |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-run pulse |
| err_align | output | 1 | Offset was not buffer-aligned |
| err_prog | output | 1 | Flash reported a program error |
| err_tmo | output | 1 | A poll loop ran out |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word accepted when high with in_valid |
| in_data | input | DW | Stream word |
| in_last | input | 1 | Marks the final stream word |
| fl_addr | output | AW | Flash bus address |
| fl_wdata | output | DW | Flash bus write data |
| fl_we | output | 1 | One-cycle write strobe |
| fl_re | output | 1 | One-cycle read strobe; data is sampled two cycles later |
| fl_rdata | input | DW | Flash status/read data |

## Verification
The sequence is run with several stream lengths. An exact single buffer separates correct exit timing from an extra buffer. A 40-word stream shows padding and the step into a second buffer without a new setup. A 5-word stream with a flagged error checks error reporting, and a stream that overruns the block end shows the forced exit and the words left unconsumed. The flash model holds the ready bit busy for a varying number of reads and delays the exit bit, so a write sent too early is caught. A flash that never becomes ready exercises the timeout, and an odd offset exercises the alignment reject. Data words equal to command codes show that stream data is never decoded.

// File: rtl/bufprog_pkg.sv
package bufprog_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SET1,
    S_SET2,
    S_RDQ,
    S_RDW,
    S_RDC,
    S_WORD,
    S_EXIT
  } seq_state_t;

  localparam int SB_RDY  = 0;
  localparam int SB_ERR  = 4;
  localparam int SB_EXIT = 7;

endpackage

// File: rtl/bufprog_addr.sv
module bufprog_addr #(
  parameter int AW    = 24,
  parameter int BLK_W = 8,
  parameter int BIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [AW-1:0]     blk_base,
  input  logic [BLK_W-1:0]  start_off,
  output logic              misaligned,
  output logic [AW-1:0]     start_addr,
  output logic [AW-1:0]     exit_addr
);

  localparam int HI_W = AW - BLK_W;

  logic [HI_W-1:0] blk_num;

  assign blk_num    = blk_base[AW-1:BLK_W];
  assign misaligned = |start_off[BIDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      start_addr <= '0;
      exit_addr  <= '0;
    end else if (load) begin
      start_addr <= {blk_num, start_off};
      exit_addr  <= {blk_num + HI_W'(1), {BLK_W{1'b0}}};
    end
  end

endmodule

// File: rtl/bufprog_cnt.sv
module bufprog_cnt #(
  parameter int BUF_WORDS = 32,
  parameter int BLK_WORDS = 256,
  localparam int BIDX_W = $clog2(BUF_WORDS),
  localparam int BLK_W  = $clog2(BLK_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BLK_W-1:0]  off,
  input  logic              step,
  output logic              buf_last,
  output logic              blk_last
);

  logic [BIDX_W-1:0] idx;
  logic [BLK_W-1:0]  pos;

  assign buf_last = (idx == BIDX_W'(BUF_WORDS - 1));
  assign blk_last = (pos == BLK_W'(BLK_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      pos <= '0;
    end else if (load) begin
      idx <= '0;
      pos <= off;
    end else if (step) begin
      idx <= buf_last ? '0 : idx + BIDX_W'(1);
      pos <= pos + BLK_W'(1);
    end
  end

endmodule

// File: rtl/bufprog_tmr.sv
module bufprog_tmr #(
  parameter int TMO_POLLS = 16,
  localparam int CW = $clog2(TMO_POLLS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic miss,
  output logic expired
);

  logic [CW-1:0] cnt;

  assign expired = miss && (cnt == CW'(TMO_POLLS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (miss && !expired) begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/bufprog_seq.sv
module bufprog_seq
  import bufprog_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int BUF_WORDS = 32,
  parameter int BLK_WORDS = 256,
  parameter int TMO_POLLS = 16,
  parameter logic [DW-1:0] CMD_SETUP   = DW'(16'h0080),
  parameter logic [DW-1:0] CMD_CONFIRM = DW'(16'h00D0),
  localparam int BIDX_W = $clog2(BUF_WORDS),
  localparam int BLK_W  = $clog2(BLK_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     blk_base,
  input  logic [BLK_W-1:0]  start_off,
  output logic              busy,
  output logic              done,
  output logic              err_align,
  output logic              err_prog,
  output logic              err_tmo,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic              in_last,
  output logic [AW-1:0]     fl_addr,
  output logic [DW-1:0]     fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [DW-1:0]     fl_rdata
);

  seq_state_t state;

  logic          in_exit;
  logic          pad;
  logic          to_exit;
  logic          misaligned;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] exit_addr;
  logic          buf_last;
  logic          blk_last;
  logic          tmo_exp;
  logic          accept;
  logic          word_go;
  logic          poll_ok;
  logic          poll_chk;

  assign accept   = (state == S_IDLE) && start;
  assign word_go  = (state == S_WORD) && (pad || in_valid);
  assign in_ready = (state == S_WORD) && !pad;
  assign poll_chk = (state == S_RDC);
  assign poll_ok  = in_exit ? fl_rdata[SB_EXIT] : !fl_rdata[SB_RDY];

  bufprog_addr #(
    .AW    (AW),
    .BLK_W (BLK_W),
    .BIDX_W(BIDX_W)
  ) u_addr (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .blk_base   (blk_base),
    .start_off  (start_off),
    .misaligned (misaligned),
    .start_addr (start_addr),
    .exit_addr  (exit_addr)
  );

  bufprog_cnt #(
    .BUF_WORDS(BUF_WORDS),
    .BLK_WORDS(BLK_WORDS)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .off      (start_off),
    .step     (word_go),
    .buf_last (buf_last),
    .blk_last (blk_last)
  );

  bufprog_tmr #(
    .TMO_POLLS(TMO_POLLS)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clear   ((state == S_IDLE) || (poll_chk && poll_ok)),
    .miss    (poll_chk && !poll_ok),
    .expired (tmo_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      err_align <= 1'b0;
      err_prog  <= 1'b0;
      err_tmo   <= 1'b0;
      fl_addr   <= '0;
      fl_wdata  <= '0;
      fl_we     <= 1'b0;
      fl_re     <= 1'b0;
      in_exit   <= 1'b0;
      pad       <= 1'b0;
      to_exit   <= 1'b0;
    end else begin
      done  <= 1'b0;
      fl_we <= 1'b0;
      fl_re <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            err_align <= 1'b0;
            err_prog  <= 1'b0;
            err_tmo   <= 1'b0;
            in_exit   <= 1'b0;
            pad       <= 1'b0;
            to_exit   <= 1'b0;
            if (misaligned) begin
              err_align <= 1'b1;
              done      <= 1'b1;
            end else begin
              busy  <= 1'b1;
              state <= S_SET1;
            end
          end
        end
        S_SET1: begin
          fl_we    <= 1'b1;
          fl_addr  <= start_addr;
          fl_wdata <= CMD_SETUP;
          state    <= S_SET2;
        end
        S_SET2: begin
          fl_we    <= 1'b1;
          fl_addr  <= start_addr;
          fl_wdata <= CMD_CONFIRM;
          state    <= S_RDQ;
        end
        S_RDQ: begin
          fl_re <= 1'b1;
          state <= S_RDW;
        end
        S_RDW: begin
          state <= S_RDC;
        end
        S_RDC: begin
          if (poll_ok) begin
            if (in_exit) begin
              err_prog <= fl_rdata[SB_ERR];
              done     <= 1'b1;
              busy     <= 1'b0;
              state    <= S_IDLE;
            end else begin
              state <= to_exit ? S_EXIT : S_WORD;
            end
          end else if (tmo_exp) begin
            err_tmo <= 1'b1;
            done    <= 1'b1;
            busy    <= 1'b0;
            state   <= S_IDLE;
          end else begin
            state <= S_RDQ;
          end
        end
        S_WORD: begin
          if (word_go) begin
            fl_we    <= 1'b1;
            fl_addr  <= start_addr;
            fl_wdata <= pad ? {DW{1'b1}} : in_data;
            if (!pad && in_last) pad <= 1'b1;
            if (buf_last && (pad || in_last || blk_last)) to_exit <= 1'b1;
            state <= S_RDQ;
          end
        end
        S_EXIT: begin
          fl_we    <= 1'b1;
          fl_addr  <= exit_addr;
          fl_wdata <= {DW{1'b1}};
          in_exit  <= 1'b1;
          state    <= S_RDQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bufprog_chk.sv
module bufprog_chk #(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int BUF_WORDS = 32,
  parameter int BLK_WORDS = 256,
  localparam int BIDX_W = $clog2(BUF_WORDS),
  localparam int BLK_W  = $clog2(BLK_WORDS)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [AW-1:0]     blk_base,
  input logic [BLK_W-1:0]  start_off,
  input logic              busy,
  input logic              done,
  input logic              err_align,
  input logic              err_tmo,
  input logic              in_ready,
  input logic [AW-1:0]     fl_addr,
  input logic              fl_we,
  input logic              fl_re,
  input logic [DW-1:0]     fl_rdata
);

  logic [AW-1:0] sa;
  logic [1:0]    wcnt;
  logic          re_d;
  logic          rdy_seen;
  logic          exited;
  logic          in_blk;

  assign in_blk = (fl_addr[AW-1:BLK_W] == sa[AW-1:BLK_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sa       <= '0;
      wcnt     <= '0;
      re_d     <= 1'b0;
      rdy_seen <= 1'b0;
      exited   <= 1'b0;
    end else begin
      re_d <= fl_re;
      if (start && !busy) begin
        sa       <= {blk_base[AW-1:BLK_W], start_off};
        wcnt     <= '0;
        rdy_seen <= 1'b0;
        exited   <= 1'b0;
      end else if (fl_we) begin
        rdy_seen <= 1'b0;
        if (wcnt != 2'd2) wcnt <= wcnt + 2'd1;
        if (!in_blk) exited <= 1'b1;
      end else if (re_d && !fl_rdata[0]) begin
        rdy_seen <= 1'b1;
      end
    end
  end

  p_same_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (fl_we && in_blk) |-> (fl_addr == sa));

  p_poll_first_r4: assert property (@(posedge clk) disable iff (rst)
    (fl_we && wcnt == 2'd2) |-> rdy_seen);

  p_align_rej_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !done && |start_off[BIDX_W-1:0]) |=> (done && err_align && !fl_we));

  p_exit_first_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !err_align && !err_tmo) |-> exited);

  p_tmo_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    err_tmo |-> !fl_we);

  p_ready_busy_r11: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind bufprog_seq bufprog_chk #(
  .AW       (AW),
  .DW       (DW),
  .BUF_WORDS(BUF_WORDS),
  .BLK_WORDS(BLK_WORDS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .blk_base  (blk_base),
  .start_off (start_off),
  .busy      (busy),
  .done      (done),
  .err_align (err_align),
  .err_tmo   (err_tmo),
  .in_ready  (in_ready),
  .fl_addr   (fl_addr),
  .fl_we     (fl_we),
  .fl_re     (fl_re),
  .fl_rdata  (fl_rdata)
);

// File: tb/sim_bufprog_seq.sv
module sim_bufprog_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int TMO = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] blk_base = '0;
  logic [7:0]    start_off = '0;
  logic          busy, done, err_align, err_prog, err_tmo;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_last = 1'b0;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic          fl_we, fl_re;
  logic [DW-1:0] fl_rdata = '0;

  int vecs = 0;
  int fails = 0;
  int cyc = 0;

  // stream source
  logic [DW-1:0] words [0:511];
  int  in_n = 0;
  int  in_idx = 0;
  bit  last_hs = 0;
  bit  load_req = 0;

  // flash model and expected writes
  logic [AW-1:0] exp_a [$];
  logic [DW-1:0] exp_d [$];
  logic [15:0]   cur_blk = '0;
  int  nwr = 0, nrd = 0, busy_n = 0, busy_left = 0, exit_n = 0, exit_left = 0;
  bit  perr = 0, stuck = 0, exited = 0, rdy_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bufprog_seq u0 (
    .clk(clk), .rst(rst), .start(start), .blk_base(blk_base), .start_off(start_off),
    .busy(busy), .done(done), .err_align(err_align), .err_prog(err_prog), .err_tmo(err_tmo),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  // stream driver: handshake decided by values stable between edges
  always @(negedge clk) begin
    if (load_req) begin
      in_idx   = 0;
      last_hs  = 0;
      load_req = 0;
    end else if (last_hs) begin
      in_idx++;
    end
    if (in_idx < in_n) begin
      in_valid = 1'b1;
      in_data  = words[in_idx];
      in_last  = (in_idx == in_n - 1);
    end else begin
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
    last_hs = in_valid && in_ready;
  end

  // behavioural flash: compares each write, answers each status read
  always @(negedge clk) begin
    if (!rst && fl_we) begin
      logic [AW-1:0] ea;
      logic [DW-1:0] ed;
      string tag;
      bit inb;
      inb = (fl_addr[23:8] == cur_blk);
      if (nwr < 2) tag = "R1";
      else if (!inb) tag = "R7";
      else if (fl_wdata == 16'hFFFF) tag = "R5";
      else tag = "R3";
      if (nwr >= 2) chk(rdy_seen, "R4 write without ready poll", 0, 1);
      rdy_seen = 0;
      if (exp_a.size() == 0) begin
        chk(0, "R10 unexpected write", fl_addr, 0);
      end else begin
        ea = exp_a.pop_front();
        ed = exp_d.pop_front();
        chk(fl_addr == ea, {tag, " addr"}, fl_addr, ea);
        chk(fl_wdata == ed, {tag, " data"}, fl_wdata, ed);
      end
      if (!inb) begin
        exited = 1;
        exit_left = exit_n;
      end else if (nwr >= 2) begin
        busy_left = busy_n;
      end
      nwr++;
    end
    if (!rst && fl_re) begin
      logic [DW-1:0] st;
      st = '0;
      nrd++;
      if (!exited) begin
        if (stuck || busy_left > 0) st[0] = 1'b1;
        else rdy_seen = 1;
        if (busy_left > 0) busy_left--;
      end else begin
        if (exit_left > 0) exit_left--;
        else st[7] = 1'b1;
        st[4] = perr;
      end
      fl_rdata <= st;
    end
  end

  // errk: 0 none, 1 align, 2 program, 3 timeout
  task automatic run(input logic [AW-1:0] base, input int off, input int n, input int bsy,
                     input int xn, input bit perr_i, input bit stuck_i, input int errk,
                     input int seed);
    logic [AW-1:0] sa, xa;
    int cap, taken;
    bit seen;
    sa = {base[23:8], 8'(off)};
    xa = {base[23:8] + 16'd1, 8'h00};
    for (int i = 0; i < n; i++) words[i] = 16'(i * 16'h0137 + seed);
    if (n > 7) begin
      words[3] = 16'h0070;
      words[5] = 16'h00D0;
      words[7] = 16'h0080;
    end
    exp_a.delete();
    exp_d.delete();
    taken = 0;
    if (off % 32 == 0) begin
      exp_a.push_back(sa); exp_d.push_back(16'h0080);
      exp_a.push_back(sa); exp_d.push_back(16'h00D0);
      if (!stuck_i) begin
        cap = ((n + 31) / 32) * 32;
        if (cap > 256 - off) cap = 256 - off;
        for (int i = 0; i < cap; i++) begin
          exp_a.push_back(sa);
          exp_d.push_back(i < n ? words[i] : 16'hFFFF);
        end
        exp_a.push_back(xa); exp_d.push_back(16'hFFFF);
        taken = (n < cap) ? n : cap;
      end
    end
    cur_blk = base[23:8];
    nwr = 0; nrd = 0; busy_n = bsy; busy_left = 0; exit_n = xn; exit_left = 0;
    perr = perr_i; stuck = stuck_i; exited = 0; rdy_seen = 0;
    in_n = n;
    load_req = 1;
    repeat (2) @(negedge clk);
    blk_base = base;
    start_off = 8'(off);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int k = 0; k < 20000; k++) begin
      if (done) begin
        seen = 1;
        break;
      end
      @(negedge clk);
    end
    chk(seen, "R11 done pulse", seen, 1);
    chk(err_align == (errk == 1), "R2 err_align", err_align, errk == 1);
    chk(err_prog == (errk == 2), "R8 err_prog", err_prog, errk == 2);
    chk(err_tmo == (errk == 3), "R10 err_tmo", err_tmo, errk == 3);
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(exp_a.size() == 0, "R7 writes missing", exp_a.size(), 0);
    chk(in_idx == taken, "R9 words consumed", in_idx, taken);
    chk(!in_ready && !busy, "R11 idle after run", {in_ready, busy}, 0);
    if (errk == 3) chk(nrd == TMO, "R10 poll count", nrd, TMO);
    if (errk == 1) chk(nwr == 0 && nrd == 0, "R2 no bus access", nwr + nrd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fl_we && !fl_re && !in_ready, "R11 reset state",
        {busy, done, fl_we, fl_re, in_ready}, 0);
    // R1 R3 R7: exactly one buffer, flash always ready
    run(24'h12_3456, 0, 32, 0, 0, 0, 0, 0, 11);
    // R5 R6 R12: two buffers with padding, slow ready and slow exit
    run(24'h04_0000, 64, 40, 2, 3, 0, 0, 0, 22);
    // R8: short stream, program error reported at exit
    run(24'h7F_00AA, 32, 5, 1, 1, 1, 0, 2, 33);
    // R9: stream overruns end of block
    run(24'hFF_0010, 224, 40, 0, 0, 0, 0, 0, 44);
    // R10: ready never seen
    run(24'h00_2200, 96, 8, 0, 0, 0, 1, 3, 55);
    // R2: offset off the buffer grid
    run(24'h00_3300, 3, 8, 0, 0, 0, 0, 1, 66);
    // R4 R6: long stream with mixed wait, exit after normal run
    run(24'h05_5500, 0, 97, 1, 2, 0, 0, 0, 77);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule